// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the internal engine that carries out the slow array-altering operations of a block-erasable flash device. A command front end hands it one start request at a time: page program, erase of one block, erase of every unprotected block, or programming of one block's lock bit. Before it starts, the sequencer decides whether the target may be changed. That decision uses the target block's lock bit, a write-protect pin and a high-voltage override on the reset pin. A refused request records an error and never turns the device busy.

An accepted request runs as a loop of timed pulse phases, each followed by a single verify cycle. A `verify_ok` model input stands in for the real cell check. The loop ends on the first passing verify, or it ends with an error once its iteration limit is used up. While the loop runs, the sequencer drives an active-low ready/busy pin. It also keeps the status byte that the front end returns to the host. That byte holds the ready, suspend, erase-error, program-error, block-status and sleep flags. Suspend, resume, sleep and wake requests also come from the front end. Pulling the reset/power-down pin low aborts any operation at once.

Lock bits are kept in this block as a register vector. They load from a parameter on reset and are visible on `lock_state`.

Top module: `flash_pe_seq`

## Requirements
- R1: `busy_n` is 0 exactly while an operation is pulsing or verifying. It is 1 when idle, suspended or asleep. Status bit 7 reads 1 when `busy_n` is 1.
- R2: While `rst_n` is low, any running operation is abandoned. On exit from reset, `status` reads 80H, `busy_n` reads 1 and `lock_state` equals `LOCK_INIT`.
- R3: Let a block be "guarded": its lock bit is 0 while `wp_rel` and `hv_unlock` are both 0. A block-erase start (op 1) aimed at a guarded block sets status bit 5. A page-program start (op 0) aimed at one sets status bit 4. In both cases `busy_n` stays 1 and no lock bit changes.
- R4: With `wp_rel`=1 or `hv_unlock`=1, a start on a block whose lock bit is 0 is accepted and runs.
- R5: A block erase that passes verify sets the target's lock bit to 1.
- R6: Erase-all (op 2) is never refused. When it passes, it sets every lock bit to 1 if `wp_rel` or `hv_unlock` is 1. Otherwise it leaves the lock bits as they were.
- R7: Lock-bit program (op 3) is refused with status bit 4 when `wp_rel` and `hv_unlock` are both 0. When accepted and passing, it clears the target's lock bit to 0.
- R8: Each iteration takes `PULSE_CYC` pulse cycles and then 1 verify cycle, in which `verify_ok` is sampled. A pass ends the operation. After `MAX_ITER` failed verifies the operation ends and sets status bit 5 (ops 1, 2) or bit 4 (ops 0, 3).
- R9: When a page program ends, status bit 3 is set if `over_prog` is 1 in that final verify cycle.
- R10: A `suspend` pulse while busy moves the sequencer to suspended. In that state status bit 6 is 1 and `busy_n` is 1. A `resume` pulse restarts the interrupted pulse phase while keeping the iteration count, so a first-pass operation is busy for `PULSE_CYC`+1 more cycles.
- R11: A `sleep_req` pulse while idle sets status bit 0 on the next cycle. A `sleep_req` pulse while busy takes effect when the operation ends. A `wake_req` pulse clears bit 0.
- R12: Status bits 5, 4 and 3 stay set until a `clr_err` pulse clears them. If an error occurs in the same cycle as `clr_err`, the new error is kept.
- R13: Start requests are ignored while busy, suspended or asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset/power-down, active low, asynchronous |
| hv_unlock | input | 1 | High-voltage level seen on the reset pin; overrides all lock bits |
| wp_rel | input | 1 | Write-protect pin; 1 releases lock-bit protection |
| start | input | 1 | One-cycle start request |
| start_op | input | 2 | 0 page program, 1 block erase, 2 erase all, 3 lock-bit program |
| start_blk | input | $clog2(NBLK) | Target block |
| suspend | input | 1 | Suspend request pulse |
| resume | input | 1 | Resume request pulse |
| sleep_req | input | 1 | Sleep request pulse |
| wake_req | input | 1 | Wake request pulse |
| clr_err | input | 1 | Clears status bits 5, 4, 3 |
| verify_ok | input | 1 | Model verify result, sampled in verify cycles |
| over_prog | input | 1 | Model over-program flag, sampled in the last verify of a page program |
| busy_n | output | 1 | Ready/busy, 0 while busy |
| status | output | 8 | {ready, suspended, erase err, program err, block status, 0, 0, sleep} |
| lock_state | output | NBLK | Per-block lock bits, 1 = unlocked |

## Verification
The in-line assertions check several rules on every cycle. Reset yields 80H. A refused erase start leaves the device ready with the erase flag set. Sticky error bits never clear without `clr_err`. The iteration counter stays under its limit. Sleep and suspend both imply ready, and a passing block erase unlocks its target. Other behaviour only the bench scenarios can show:

- exact busy lengths for first-pass, second-pass and exhausted loops;
- resume continuing with a fresh pulse phase;
- a deferred sleep landing at the end of an operation;
- commands ignored while suspended or asleep;
- the lock-bit results of random mixes of operations and protection settings.

// File: rtl/flash_pe_seq.sv
module flash_pe_seq #(
  parameter int NBLK      = 8,
  parameter int PULSE_CYC = 4,
  parameter int MAX_ITER  = 3,
  parameter logic [NBLK-1:0] LOCK_INIT = '0,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1,
  localparam int IW = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hv_unlock,
  input  logic            wp_rel,
  input  logic            start,
  input  logic [1:0]      start_op,
  input  logic [BW-1:0]   start_blk,
  input  logic            suspend,
  input  logic            resume,
  input  logic            sleep_req,
  input  logic            wake_req,
  input  logic            clr_err,
  input  logic            verify_ok,
  input  logic            over_prog,
  output logic            busy_n,
  output logic [7:0]      status,
  output logic [NBLK-1:0] lock_state
);
  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_VER, S_SUSP} st_t;
  typedef enum logic [1:0] {OP_PG = 2'd0, OP_BE = 2'd1, OP_EA = 2'd2, OP_LP = 2'd3} op_t;

  st_t            st;
  op_t            op;
  logic [BW-1:0]  blk;
  logic [CW-1:0]  pcnt;
  logic [IW-1:0]  iter;
  logic           e5, e4, bs3, sleeping, spend;
  logic [NBLK-1:0] lock;

  wire guard    = !wp_rel && !hv_unlock;
  wire accept   = (st == S_IDLE) && start && !sleeping && !sleep_req && !spend;
  wire tgt_prot = guard && !lock[start_blk];
  wire refuse   = accept && ((((start_op == OP_PG) || (start_op == OP_BE)) && tgt_prot) ||
                             ((start_op == OP_LP) && guard));
  wire go       = accept && !refuse;
  wire last_it  = (iter == IW'(MAX_ITER - 1));
  wire is_erase = (op == OP_BE) || (op == OP_EA);

  assign busy_n     = (st == S_IDLE) || (st == S_SUSP);
  assign status     = {busy_n, st == S_SUSP, e5, e4, bs3, 2'b00, sleeping};
  assign lock_state = lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_PG; blk <= '0; pcnt <= '0; iter <= '0;
      e5 <= 1'b0; e4 <= 1'b0; bs3 <= 1'b0; sleeping <= 1'b0; spend <= 1'b0;
      lock <= LOCK_INIT;
    end else begin
      if (clr_err) begin e5 <= 1'b0; e4 <= 1'b0; bs3 <= 1'b0; end
      if (sleep_req) spend <= 1'b1;
      unique case (st)
        S_IDLE: begin
          if (sleep_req || spend) begin
            sleeping <= 1'b1; spend <= 1'b0;
          end else if (go) begin
            st <= S_PULSE; op <= op_t'(start_op); blk <= start_blk;
            pcnt <= '0; iter <= '0;
          end else if (refuse) begin
            if (start_op == OP_BE) e5 <= 1'b1;
            else e4 <= 1'b1;
          end
        end
        S_PULSE: begin
          if (suspend) begin
            st <= S_SUSP; pcnt <= '0;
          end else if (pcnt == CW'(PULSE_CYC - 1)) begin
            st <= S_VER;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_VER: begin
          if (suspend) begin
            st <= S_SUSP; pcnt <= '0;
          end else if (verify_ok || last_it) begin
            st <= S_IDLE;
            if (op == OP_PG) bs3 <= (bs3 && !clr_err) || over_prog;
            if (verify_ok) begin
              unique case (op)
                OP_BE:   lock[blk] <= 1'b1;
                OP_EA:   if (!guard) lock <= '1;
                OP_LP:   lock[blk] <= 1'b0;
                default: ;
              endcase
            end else if (is_erase) e5 <= 1'b1;
            else e4 <= 1'b1;
            if (spend || sleep_req) begin sleeping <= 1'b1; spend <= 1'b0; end
          end else begin
            iter <= iter + 1'b1; pcnt <= '0; st <= S_PULSE;
          end
        end
        S_SUSP: if (resume) st <= S_PULSE;
        default: st <= S_IDLE;
      endcase
      if (wake_req) begin sleeping <= 1'b0; spend <= 1'b0; end
    end
  end

  // R2: reset exit value
  a_r2_reset_status: assert property (@(posedge clk) !rst_n |=> (status == 8'h80) && busy_n);
  // R3: refused erase never goes busy and flags the erase error
  a_r3_refused_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (start_op == OP_BE) && tgt_prot) |=> busy_n && status[5]);
  // R5: passing block erase unlocks its target
  a_r5_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_VER) && !suspend && verify_ok && (op == OP_BE)) |=> lock_state[blk]);
  // R8: iteration count stays within its limit
  a_r8_iter_bound: assert property (@(posedge clk) disable iff (!rst_n) iter < IW'(MAX_ITER) || MAX_ITER == 1);
  // R10: a suspended state only appears after a suspend request, and reads ready
  a_r10_susp_cause: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[6]) |-> $past(suspend));
  a_r10_susp_ready: assert property (@(posedge clk) disable iff (!rst_n) status[6] |-> busy_n);
  // R11: sleep never coexists with a running operation
  a_r11_sleep_ready: assert property (@(posedge clk) disable iff (!rst_n) status[0] |-> busy_n);
  // R12: error bits are sticky without clr_err
  a_r12_e5_sticky: assert property (@(posedge clk) disable iff (!rst_n) (status[5] && !clr_err) |=> status[5]);
  a_r12_e4_sticky: assert property (@(posedge clk) disable iff (!rst_n) (status[4] && !clr_err) |=> status[4]);
endmodule

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int P  = 4;
  localparam int M  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv_unlock = 0, wp_rel = 0, start = 0, suspend = 0, resume = 0;
  logic sleep_req = 0, wake_req = 0, clr_err = 0, verify_ok = 1, over_prog = 0;
  logic [1:0] start_op = '0;
  logic [2:0] start_blk = '0;
  logic busy_n;
  logic [7:0] status;
  logic [NB-1:0] lock_state;

  int n_chk = 0, n_fail = 0;
  logic [NB-1:0] m_lock;
  logic m_e5, m_e4, m_bs;
  int seed_dummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pe_seq #(.NBLK(NB), .PULSE_CYC(P), .MAX_ITER(M)) u_flash_pe_seq (
    .clk, .rst_n, .hv_unlock, .wp_rel, .start, .start_op, .start_blk, .suspend, .resume,
    .sleep_req, .wake_req, .clr_err, .verify_ok, .over_prog, .busy_n, .status, .lock_state);

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    report();
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(logic susp, logic slp);
    return {1'b1, susp, m_e5, m_e4, m_bs, 2'b00, slp};
  endfunction

  // Drive one start, count busy cycles; flip verify_ok to 1 after flip samples (0 = never)
  task automatic run_op(input logic [1:0] op, input logic [2:0] b, input int flip, output int cyc);
    @(negedge clk);
    start = 1; start_op = op; start_blk = b;
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (!busy_n && cyc < 1000) begin
      cyc++;
      if (flip != 0 && cyc == flip) verify_ok = 1;
      @(negedge clk);
    end
  endtask

  // Reference model of one start with constant verify_ok
  task automatic model_op(input logic [1:0] op, input logic [2:0] b, input logic pass,
                          input logic ovp, output int cyc);
    logic grd;
    grd = !wp_rel && !hv_unlock;
    cyc = pass ? P + 1 : M * (P + 1);
    case (op)
      2'd0: if (grd && !m_lock[b]) begin m_e4 = 1; cyc = 0; end
            else begin m_bs = m_bs | ovp; if (!pass) m_e4 = 1; end
      2'd1: if (grd && !m_lock[b]) begin m_e5 = 1; cyc = 0; end
            else if (pass) m_lock[b] = 1; else m_e5 = 1;
      2'd2: if (pass) begin if (!grd) m_lock = '1; end else m_e5 = 1;
      default: if (grd) begin m_e4 = 1; cyc = 0; end
               else if (pass) m_lock[b] = 0; else m_e4 = 1;
    endcase
  endtask

  task automatic pulse_clr;
    @(negedge clk); clr_err = 1; @(negedge clk); clr_err = 0;
    m_e5 = 0; m_e4 = 0; m_bs = 0;
  endtask

  initial begin
    int cyc, ecyc;
    seed_dummy = $urandom(32'h5eed);
    m_lock = '0; m_e5 = 0; m_e4 = 0; m_bs = 0;
    repeat (3) @(negedge clk);
    check("R2 reset status", {24'h0, status}, 32'h80);
    check("R2 reset busy_n", {31'h0, busy_n}, 1);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset locks", {24'h0, lock_state}, {24'h0, m_lock});

    // R3: guarded erase refused
    run_op(2'd1, 3'd2, 0, cyc);
    check("R3 refused erase busy cycles", cyc, 0);
    check("R3 refused erase status", {24'h0, status}, 32'hA0);
    check("R3 lock unchanged", {24'h0, lock_state}, 0);
    // R7: lock program refused under guard
    run_op(2'd3, 3'd1, 0, cyc);
    check("R7 refused lock program", {24'h0, status}, 32'hB0);
    // R12: sticky until clear
    repeat (4) @(negedge clk);
    check("R12 sticky errors", {24'h0, status}, 32'hB0);
    pulse_clr();
    @(negedge clk);
    check("R12 cleared", {24'h0, status}, 32'h80);

    // R4/R5: hv override, erase passes first time
    hv_unlock = 1;
    run_op(2'd1, 3'd3, 0, cyc);
    check("R8 first-pass busy cycles", cyc, P + 1);
    check("R5 erase unlocks block 3", {31'h0, lock_state[3]}, 1);
    m_lock[3] = 1;
    hv_unlock = 0;

    // R8: pass on second iteration
    wp_rel = 1; verify_ok = 0;
    run_op(2'd1, 3'd4, P + 2, cyc);
    check("R8 second-pass busy cycles", cyc, 2 * (P + 1));
    check("R4 erase with wp_rel unlocks block 4", {31'h0, lock_state[4]}, 1);
    m_lock[4] = 1;
    // R8: exhaust iterations on page program, R9 over-program flag
    verify_ok = 0; over_prog = 1;
    run_op(2'd0, 3'd0, 0, cyc);
    check("R8 exhausted busy cycles", cyc, M * (P + 1));
    check("R8 R9 program fail status", {24'h0, status}, 32'h98);
    over_prog = 0; verify_ok = 1;
    pulse_clr();

    // R10: suspend and resume
    @(negedge clk); start = 1; start_op = 2'd1; start_blk = 3'd5;
    @(negedge clk); start = 0;
    @(negedge clk); suspend = 1;
    @(negedge clk); suspend = 0;
    check("R10 suspended status", {24'h0, status}, 32'hC0);
    check("R10 suspended busy_n", {31'h0, busy_n}, 1);
    start = 1; start_op = 2'd3; start_blk = 3'd3;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    check("R13 start ignored while suspended", {24'h0, lock_state}, {24'h0, m_lock});
    check("R10 still suspended", {24'h0, status}, 32'hC0);
    resume = 1;
    @(negedge clk); resume = 0;
    cyc = 0;
    while (!busy_n && cyc < 1000) begin cyc++; @(negedge clk); end
    check("R10 busy after resume", cyc, P + 1);
    check("R10 resumed erase unlocks block 5", {31'h0, lock_state[5]}, 1);
    m_lock[5] = 1;

    // R11: sleep during operation is deferred
    @(negedge clk); start = 1; start_op = 2'd0; start_blk = 3'd6;
    @(negedge clk); start = 0;
    check("R1 busy during program", {31'h0, busy_n}, 0);
    sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    check("R11 sleep deferred while busy", {31'h0, status[0]}, 0);
    while (!busy_n) @(negedge clk);
    check("R11 asleep after completion", {24'h0, status}, 32'h81);
    run_op(2'd1, 3'd0, 0, cyc);
    check("R13 start ignored while asleep", cyc, 0);
    check("R13 locks unchanged while asleep", {24'h0, lock_state}, {24'h0, m_lock});
    @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;
    check("R11 wake clears sleep", {24'h0, status}, 32'h80);
    @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
    check("R11 idle sleep immediate", {24'h0, status}, 32'h81);
    @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;

    // R6: erase-all under guard leaves locked blocks, without guard unlocks all
    wp_rel = 0;
    run_op(2'd2, 3'd0, 0, cyc);
    check("R6 erase-all runs under guard", cyc, P + 1);
    check("R6 guarded locks kept", {24'h0, lock_state}, {24'h0, m_lock});
    wp_rel = 1;
    run_op(2'd7 & 2'd3, 3'd1, 0, cyc);
    m_lock[1] = 0;
    check("R7 lock program clears bit", {24'h0, lock_state}, {24'h0, m_lock});
    run_op(2'd2, 3'd0, 0, cyc);
    m_lock = '1;
    check("R6 erase-all unlocks all", {24'h0, lock_state}, {24'h0, m_lock});

    // R2: reset aborts
    @(negedge clk); start = 1; start_op = 2'd3; start_blk = 3'd2;
    @(negedge clk); start = 0;
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R2 abort busy_n", {31'h0, busy_n}, 1);
    check("R2 abort status", {24'h0, status}, 32'h80);
    check("R2 abort locks", {24'h0, lock_state}, 0);
    rst_n = 1;
    m_lock = '0; m_e5 = 0; m_e4 = 0; m_bs = 0;

    // Random mix checked against the model
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op;
      logic [2:0] b;
      logic pass, ovp;
      op = 2'($urandom % 4);
      b = 3'($urandom % NB);
      pass = ($urandom % 3) != 0;
      ovp = ($urandom % 4) == 0;
      wp_rel = ($urandom % 2) == 0;
      hv_unlock = ($urandom % 5) == 0;
      verify_ok = pass; over_prog = ovp;
      model_op(op, b, pass, ovp, ecyc);
      run_op(op, b, 0, cyc);
      check("R8 random busy cycles", cyc, ecyc);
      check("R3 R5 R6 R7 random locks", {24'h0, lock_state}, {24'h0, m_lock});
      check("R8 R9 R12 random status", {24'h0, status}, {24'h0, exp_status(0, 0)});
      if ((i % 7) == 6) pulse_clr();
    end
    report();
  end
endmodule